// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a successive-approximation analog-to-digital converter. A single-cycle `go` pulse makes it strobe an external sample/hold stage. It then finds an N-bit code by binary search. Each trial sets one candidate bit, starting at the most significant one. The candidate code drives an external DAC, and one external comparator bit decides whether the candidate bit is kept. When the least significant bit has been decided, the result appears on `data_o` and `done_o` goes high.

Every trial waits a programmable number of settle cycles before the comparator is read. The comparator passes through a two-flop synchronizer. The timing therefore does not depend on the input, so a conversion always takes the same number of cycles. A `go` that arrives while a conversion is running has no effect. The finished result and `done_o` stay valid until the next accepted `go`.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `done_o`, `hold_o`, `data_o` and `dac_code_o` are all zero. A reset that arrives during a conversion abandons it.
- R2: A `go` sampled high in idle raises `hold_o` on the next cycle. `hold_o` stays high for exactly SAMPLE_CYC cycles, and no trial code is driven while it is high (`dac_code_o` = 0).
- R3: The first trial code has only bit DATA_W-1 set (for example 8'b1000_0000).
- R4: After each trial on bit i, bit i is kept if the comparator was high (held input above the DAC output) and cleared if it was low. The next trial code also sets bit i-1. Higher bits are never changed again.
- R5: The comparator is read through two synchronizing flops.
- R6: Each trial code stays on `dac_code_o` for exactly SETTLE_CYC+3 cycles: SETTLE_CYC settle cycles, 2 synchronizer cycles and 1 decision cycle.
- R7: `done_o` rises exactly SAMPLE_CYC + DATA_W*(SETTLE_CYC+3) clock edges after the edge that accepted `go`. This latency does not depend on the input.
- R8: The result is the largest code c for which the held input exceeds c LSB, or 0 if there is no such code. For an input between 2 and 3 LSB, a 3-bit conversion tries 100, 010, 011 and returns 010.
- R9: A `go` pulse seen while sampling or trialling is ignored. Timing, trial codes and result are unchanged.
- R10: `done_o` and `data_o` hold their values while idle until the next accepted `go`. That `go` clears `done_o` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Start request, sampled in idle |
| cmp_in | input | 1 | Asynchronous comparator result, high when held input exceeds DAC output |
| hold_o | output | 1 | Sample/hold strobe, high while the input is being captured |
| dac_code_o | output | DATA_W | Trial code for the external DAC |
| data_o | output | DATA_W | Last conversion result |
| done_o | output | 1 | Result valid |

## Verification
The stimulus mixes random input levels with directed ones at zero, at full scale, exactly on a code boundary and between two codes. A boundary input separates "greater than" from "greater or equal" in the keep/clear decision. A between-codes input shows that the result truncates. Random `go` pulses during a conversion show whether a busy sequencer restarts or shifts its timing. Sampling the trial code at the first and last cycle of every trial checks both the search path and the dwell time of each trial. A reset in the middle of a conversion checks that the partial state is abandoned.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_TRIAL  = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

    // R5: the output follows the input STAGES edges later (checked for two stages)
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (STAGES == 2) && $past(!rst) |=> sync_o == $past(async_i, 2))
        else $error("R5: synchronizer latency wrong");
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R6: an unloaded expired timer never wraps around
    a_r6_timer_no_wrap: assert property (@(posedge clk) disable iff (rst)
        zero_o && !load_i |=> zero_o)
        else $error("R6: timer wrapped");
endmodule

// File: rtl/sar_core.sv
module sar_core
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 2,
    parameter int WAIT_CYC   = 4,
    parameter int TW         = 3,
    parameter int IW         = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              cmp_s,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_val,
    output logic              hold_o,
    output logic [DATA_W-1:0] code_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        sar_state_e        state;
        logic [IW-1:0]     idx;
        logic [DATA_W-1:0] code;
        logic [DATA_W-1:0] data;
        logic              done;
    } core_t;

    core_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (go) begin
                    r_d.state = ST_SAMPLE;
                    r_d.done  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SAMPLE_CYC - 1);
                end
            end
            ST_SAMPLE: begin
                if (tmr_zero) begin
                    r_d.state = ST_TRIAL;
                    r_d.code  = MSB_ONLY;
                    r_d.idx   = IW'(DATA_W - 1);
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(WAIT_CYC);
                end
            end
            ST_TRIAL: begin
                if (tmr_zero) begin
                    if (!cmp_s) r_d.code[r_q.idx] = 1'b0;
                    if (r_q.idx == '0) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                        r_d.data  = r_d.code;
                        r_d.code  = '0;
                    end else begin
                        r_d.idx                 = r_q.idx - 1'b1;
                        r_d.code[r_q.idx - 1'b1] = 1'b1;
                        tmr_load                = 1'b1;
                        tmr_val                 = TW'(WAIT_CYC);
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.idx   <= '0;
            r_q.code  <= '0;
            r_q.data  <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_o = (r_q.state == ST_SAMPLE);
    assign code_o = r_q.code;
    assign data_o = r_q.data;
    assign done_o = r_q.done;

    // R3: leaving the sample phase presents a code with only the MSB set
    a_r3_first_trial_msb: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_SAMPLE) && tmr_zero |=> code_o == MSB_ONLY)
        else $error("R3: first trial code wrong");

    // R6: the trial code is held steady while the settle timer runs
    a_r6_code_steady: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_TRIAL) && !tmr_zero |=> $stable(code_o))
        else $error("R6: code moved during settle");

    // R9: a go during sampling does not return the sequencer to idle
    a_r9_go_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_SAMPLE) && go |=> r_q.state != ST_IDLE)
        else $error("R9: busy go disturbed sequencing");

    // R10: a finished result holds until a new go
    a_r10_result_holds: assert property (@(posedge clk) disable iff (rst)
        done_o && !go |=> done_o && $stable(data_o))
        else $error("R10: result not held");

    // R2: no trial code is driven while sampling
    a_r2_hold_no_code: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (code_o == '0) && !done_o)
        else $error("R2: code or done during sampling");
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 2,
    parameter int SETTLE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              cmp_in,
    output logic              hold_o,
    output logic [DATA_W-1:0] dac_code_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o
);
    localparam int SYNC_STAGES = 2;
    localparam int WAIT_CYC    = SETTLE_CYC + SYNC_STAGES;
    localparam int MAX_LOAD    = (WAIT_CYC > SAMPLE_CYC) ? WAIT_CYC : SAMPLE_CYC;
    localparam int TW          = $clog2(MAX_LOAD + 1);
    localparam int IW          = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic          cmp_s;
    logic          tmr_load;
    logic          tmr_zero;
    logic [TW-1:0] tmr_val;

    sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cmp_in),
        .sync_o  (cmp_s)
    );

    sar_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    sar_core #(
        .DATA_W     (DATA_W),
        .SAMPLE_CYC (SAMPLE_CYC),
        .WAIT_CYC   (WAIT_CYC),
        .TW         (TW),
        .IW         (IW)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .cmp_s    (cmp_s),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .hold_o   (hold_o),
        .code_o   (dac_code_o),
        .data_o   (data_o),
        .done_o   (done_o)
    );
endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
    localparam int N   = 8;
    localparam int SMP = 2;
    localparam int STL = 2;
    localparam int TRL = STL + 3;
    localparam int LAT = SMP + N * TRL;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic go  = 1'b0;
    logic cmp_in;
    logic hold_o, done_o;
    logic [N-1:0] dac_code_o, data_o;

    int vin = 0;     // analog input in quarter-LSB units
    int held = 0;    // value captured by the modelled sample/hold
    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) if (hold_o) held <= vin;
    assign cmp_in = (held > (int'(dac_code_o) * 4));

    sar_sequencer #(.DATA_W(N), .SAMPLE_CYC(SMP), .SETTLE_CYC(STL)) uut (
        .clk(clk), .rst(rst), .go(go), .cmp_in(cmp_in),
        .hold_o(hold_o), .dac_code_o(dac_code_o), .data_o(data_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_result(input int f);
        return (f <= 0) ? 0 : (f - 1) >> 2;
    endfunction

    function automatic int exp_trial(input int f, input int t);
        int code = 0;
        for (int j = 0; j < t; j++) begin
            int trial = code | (1 << (N - 1 - j));
            if (f > trial * 4) code = trial;
        end
        return code | (1 << (N - 1 - t));
    endfunction

    task automatic convert(input int f, input bit noisy);
        int t_start, t_end;
        @(negedge clk);
        vin = f;
        go  = 1'b1;
        for (int k = 1; k <= LAT + 1; k++) begin
            @(negedge clk);
            go = (noisy && k < LAT - 1) ? 1'($urandom_range(0, 1)) : 1'b0;
            if (k == 1) begin
                chk(hold_o == 1'b1, "R2 hold rises", int'(hold_o), 1);
                chk(done_o == 1'b0, "R10 go clears done", int'(done_o), 0);
            end
            if (k == SMP) chk(hold_o && dac_code_o == 0, "R2 hold without code", int'(dac_code_o), 0);
            if (k == SMP + 1) chk(hold_o == 1'b0, "R2 hold width", int'(hold_o), 0);
            for (int t = 0; t < N; t++) begin
                t_start = SMP + 1 + t * TRL;
                t_end   = SMP + (t + 1) * TRL;
                if (k == t_start)
                    chk(int'(dac_code_o) == exp_trial(f, t), (t == 0) ? "R3 first trial" :
                        (noisy ? "R9 R4 trial code" : "R4 trial code"), int'(dac_code_o), exp_trial(f, t));
                if (k == t_end)
                    chk(int'(dac_code_o) == exp_trial(f, t), "R6 R5 trial dwell", int'(dac_code_o), exp_trial(f, t));
            end
            if (k == LAT) chk(done_o == 1'b0, "R7 done not early", int'(done_o), 0);
            if (k == LAT + 1) begin
                chk(done_o == 1'b1, noisy ? "R9 R7 done latency" : "R7 done latency", int'(done_o), 1);
                chk(int'(data_o) == exp_result(f), noisy ? "R9 R8 result" : "R8 result", int'(data_o), exp_result(f));
            end
        end
        vin = 0;
        repeat (3) @(negedge clk);
        chk(done_o && int'(data_o) == exp_result(f), "R10 result held", int'(data_o), exp_result(f));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(!done_o && !hold_o && data_o == 0 && dac_code_o == 0, "R1 reset state", int'(data_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done_o && !hold_o && data_o == 0, "R1 after reset", int'(done_o), 0);

        convert(10, 1'b0);          // between 2 and 3 LSB
        convert(8, 1'b0);           // exactly on a code boundary
        convert(0, 1'b0);           // bottom of range
        convert(4 * (1 << N) - 1, 1'b0);  // top of range
        convert(513, 1'b1);         // busy go pulses

        for (int i = 0; i < 40; i++)
            convert(int'($urandom_range(0, 4 * (1 << N) - 1)), 1'($urandom_range(0, 1)));

        // R1: reset in the middle of a conversion
        @(negedge clk); vin = 700; go = 1'b1;
        @(negedge clk); go = 1'b0;
        repeat (SMP + 4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!done_o && !hold_o && data_o == 0 && dac_code_o == 0, "R1 mid-conversion reset", int'(dac_code_o), 0);
        rst = 1'b0;
        convert(300, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule